// File: doc/BRIEF.md
# Endian-Selectable Bus Width Matcher

This block connects a 36-bit long-word FIFO interface to an external port that can be 36, 18 or 9 bits wide. On the read side it takes one long-word from the FIFO and hands it out as one, two or four sub-words on successive port read strobes. On the write side it collects narrow writes from the port and pushes one assembled long-word to the FIFO once the last sub-word of the group has arrived. The order of sub-words is big endian or little endian.

The width and the order are captured from three configuration pins while master reset is held low, and they stay fixed until the next master reset. A partial reset keeps that captured configuration. It clears only the sub-word positions, so that both paths restart on a long-word boundary. The FIFO handshakes are combinational: a pop or push happens in the same cycle as the port access that needs it. Narrow read data leaves the block one cycle after the read strobe is accepted.

Each path is a two-state machine. The read path has `RD_EMPTY` (no long-word held) and `RD_HOLD` (sub-words of a popped long-word remain). `RD_EMPTY -> RD_HOLD` occurs on an accepted read that pops a long-word with more than one part. `RD_HOLD -> RD_EMPTY` occurs on the accepted read of the last part. The write path has `WR_EMPTY` (no partial long-word) and `WR_FILL` (some parts gathered). `WR_EMPTY -> WR_FILL` occurs on an accepted first write when the group has more than one part. `WR_FILL -> WR_EMPTY` occurs on the accepted write of the last part, which is also the push. Either reset forces both machines to their empty state.

Top module: `bus_width_matcher`

## Requirements
- R1: Width decode at master reset: `narrow_en`=0 selects 36-bit long-word transfers (one part). `narrow_en`=1 with `lane_sel`=1 selects 9-bit bytes (four parts). `narrow_en`=1 with `lane_sel`=0 selects 18-bit words (two parts). Narrow read data appears in `port_rd_data[w-1:0]` with all higher bits zero. Only `port_wr_data[w-1:0]` is used on writes, where w is the part width.
- R2: `narrow_en`, `lane_sel` and `big_sel` are sampled only on clock edges while `mrst_n` is low. Changing them later has no effect on either path.
- R3: Big endian read (`big_sel`=1 at reset): the first part delivered is the most significant part of the long-word (bits 35:27 for bytes, 35:18 for words), then parts in descending significance.
- R4: Little endian read: the first part delivered is the least significant (bits 8:0 or 17:0), then parts in ascending significance.
- R5: Big endian write: the first part written becomes the most significant part of the pushed long-word, and the last written becomes the least significant.
- R6: Little endian write: the first part written becomes the least significant part of the pushed long-word.
- R7: `rd_fifo_pop` is high only in a cycle where a port read is accepted and no part of an earlier long-word remains held. A long-word yields exactly one pop per group of reads.
- R8: `wr_fifo_push` is high only in the cycle the last part of a group is accepted. That part is accepted only while `wr_fifo_ready` is high. Earlier parts are accepted regardless of `wr_fifo_ready`.
- R9: A low on `prst_n` clears both part positions, so the next read pops a fresh long-word and the next write starts a new group. The width and order captured at the last master reset are kept.
- R10: `port_rd_rdy` is high when a part is held or `rd_fifo_valid` is high. An accepted read (`port_rd_req` with `port_rd_rdy`) gives `port_rd_vld`=1 with its data in the next cycle. In any other cycle `port_rd_vld` is 0.
- R11: While `mrst_n` or `prst_n` is low, `port_rd_rdy`, `port_wr_rdy`, `rd_fifo_pop` and `wr_fifo_push` are all 0. After reset, `port_rd_vld` and `port_rd_data` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; captures configuration |
| prst_n | input | 1 | Partial reset, active low, synchronous; clears positions only |
| narrow_en | input | 1 | 1 selects a narrow port width (sampled in master reset) |
| lane_sel | input | 1 | With narrow_en: 1 byte width, 0 word width |
| big_sel | input | 1 | 1 big endian, 0 little endian (sampled in master reset) |
| port_rd_req | input | 1 | Port read strobe |
| port_rd_rdy | output | 1 | A part can be read this cycle |
| port_rd_vld | output | 1 | port_rd_data holds a part read in the previous cycle |
| port_rd_data | output | 36 | Read part, zero extended |
| rd_fifo_valid | input | 1 | FIFO has a long-word on rd_fifo_data |
| rd_fifo_data | input | 36 | Head long-word of the FIFO |
| rd_fifo_pop | output | 1 | Removes the head long-word |
| port_wr_req | input | 1 | Port write strobe |
| port_wr_data | input | 36 | Write part in the low bits |
| port_wr_rdy | output | 1 | A part can be written this cycle |
| wr_fifo_ready | input | 1 | FIFO can take a long-word |
| wr_fifo_push | output | 1 | Pushes wr_fifo_data into the FIFO |
| wr_fifo_data | output | 36 | Assembled long-word |

## Verification
The bench reads and writes the same patterns in both orders at all three widths. A design that swapped the shift direction or the lane slice would return the parts reversed. The write data carries junk above the part width, so missing masking would corrupt the assembled word. Each read group is checked for exactly one pop on its first access and each write group for a push only on its last. A counter with an off-by-one would pop or push a part early or late. A partial reset in the middle of a group, with the configuration pins changed beforehand, must give a fresh pop and a full new write group while the old width and order stay in force. A design that left the counters alone would return a stale part, and one that recaptured the pins would change width. Stalling the last write on a full FIFO and reading with an empty FIFO show whether the ready outputs and strobes are held back.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    // Port width selected at master reset
    typedef enum logic [1:0] {
        WIDTH_LONG = 2'd0,
        WIDTH_HALF = 2'd1,
        WIDTH_LANE = 2'd2
    } width_e;

endpackage

// File: rtl/bwm_cfg.sv
module bwm_cfg
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES,
    localparam int SH_W   = $clog2(DATA_W + 1),
    localparam int CNT_W  = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             narrow_en,
    input  logic             lane_sel,
    input  logic             big_sel,
    output width_e           mode_q,
    output logic             big_q,
    output logic [SH_W-1:0]  part_w_q,
    output logic [CNT_W-1:0] last_idx_q
);

    width_e           mode_d;
    logic [SH_W-1:0]  part_w_d;
    logic [CNT_W-1:0] last_idx_d;

    always_comb begin
        unique case ({narrow_en, lane_sel})
            2'b10:   mode_d = WIDTH_HALF;
            2'b11:   mode_d = WIDTH_LANE;
            default: mode_d = WIDTH_LONG;
        endcase
    end

    always_comb begin
        unique case (mode_d)
            WIDTH_HALF: begin
                part_w_d   = SH_W'(DATA_W / 2);
                last_idx_d = CNT_W'(1);
            end
            WIDTH_LANE: begin
                part_w_d   = SH_W'(LANE_W);
                last_idx_d = CNT_W'(LANES - 1);
            end
            default: begin
                part_w_d   = SH_W'(DATA_W);
                last_idx_d = '0;
            end
        endcase
    end

    // Captured only while master reset is held
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q     <= mode_d;
            big_q      <= big_sel;
            part_w_q   <= part_w_d;
            last_idx_q <= last_idx_d;
        end
    end

endmodule

// File: rtl/bwm_unpack.sv
module bwm_unpack #(
    parameter int DATA_W = 36,
    parameter int SH_W   = 6,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              big,
    input  logic [SH_W-1:0]   part_w,
    input  logic [CNT_W-1:0]  last_idx,
    input  logic              port_rd_req,
    output logic              port_rd_rdy,
    output logic              port_rd_vld,
    output logic [DATA_W-1:0] port_rd_data,
    input  logic              rd_fifo_valid,
    input  logic [DATA_W-1:0] rd_fifo_data,
    output logic              rd_fifo_pop
);

    typedef enum logic {RD_EMPTY = 1'b0, RD_HOLD = 1'b1} rd_state_e;

    localparam logic [DATA_W-1:0] ONES = '1;
    localparam logic [SH_W-1:0]   DW_S = SH_W'(DATA_W);

    rd_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] src, part_mask, sub, rest;
    logic              take;

    always_comb begin
        src         = (state_q == RD_EMPTY) ? rd_fifo_data : hold_q;
        port_rd_rdy = !clr && ((state_q == RD_HOLD) || rd_fifo_valid);
        take        = port_rd_req && port_rd_rdy;
        rd_fifo_pop = take && (state_q == RD_EMPTY);
        part_mask   = ~(ONES << part_w);
        sub         = big ? (src >> (DW_S - part_w)) : (src & part_mask);
        rest        = big ? (src << part_w) : (src >> part_w);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RD_EMPTY: begin
                if (take && (last_idx != '0)) begin
                    state_d = RD_HOLD;
                    cnt_d   = CNT_W'(1);
                end
            end
            RD_HOLD: begin
                if (take) begin
                    if (cnt_q == last_idx) begin
                        state_d = RD_EMPTY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q      <= RD_EMPTY;
            cnt_q        <= '0;
            hold_q       <= '0;
            port_rd_vld  <= 1'b0;
            port_rd_data <= '0;
        end else begin
            state_q     <= state_d;
            cnt_q       <= cnt_d;
            port_rd_vld <= take;
            if (take) begin
                hold_q       <= rest;
                port_rd_data <= sub;
            end
        end
    end

endmodule

// File: rtl/bwm_pack.sv
module bwm_pack #(
    parameter int DATA_W = 36,
    parameter int SH_W   = 6,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              big,
    input  logic [SH_W-1:0]   part_w,
    input  logic [CNT_W-1:0]  last_idx,
    input  logic              port_wr_req,
    input  logic [DATA_W-1:0] port_wr_data,
    output logic              port_wr_rdy,
    input  logic              wr_fifo_ready,
    output logic              wr_fifo_push,
    output logic [DATA_W-1:0] wr_fifo_data
);

    typedef enum logic {WR_EMPTY = 1'b0, WR_FILL = 1'b1} wr_state_e;

    localparam logic [DATA_W-1:0] ONES = '1;
    localparam logic [SH_W-1:0]   DW_S = SH_W'(DATA_W);

    wr_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] lane, merged;
    logic              at_last, take;

    always_comb begin
        at_last      = (cnt_q == last_idx);
        port_wr_rdy  = !clr && (!at_last || wr_fifo_ready);
        take         = port_wr_req && port_wr_rdy;
        wr_fifo_push = take && at_last;
        lane         = port_wr_data & ~(ONES << part_w);
        merged       = big ? ((acc_q << part_w) | lane)
                           : ((acc_q >> part_w) | (lane << (DW_S - part_w)));
        wr_fifo_data = merged;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WR_EMPTY: begin
                if (take && !at_last) begin
                    state_d = WR_FILL;
                    cnt_d   = CNT_W'(1);
                end
            end
            WR_FILL: begin
                if (take) begin
                    if (at_last) begin
                        state_d = WR_EMPTY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= WR_EMPTY;
            cnt_q   <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (take) acc_q <= at_last ? '0 : merged;
        end
    end

endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      mrst_n,
    input  logic                      prst_n,
    input  logic                      narrow_en,
    input  logic                      lane_sel,
    input  logic                      big_sel,
    input  logic                      port_rd_req,
    output logic                      port_rd_rdy,
    output logic                      port_rd_vld,
    output logic [LANE_W*LANES-1:0]   port_rd_data,
    input  logic                      rd_fifo_valid,
    input  logic [LANE_W*LANES-1:0]   rd_fifo_data,
    output logic                      rd_fifo_pop,
    input  logic                      port_wr_req,
    input  logic [LANE_W*LANES-1:0]   port_wr_data,
    output logic                      port_wr_rdy,
    input  logic                      wr_fifo_ready,
    output logic                      wr_fifo_push,
    output logic [LANE_W*LANES-1:0]   wr_fifo_data
);

    localparam int DATA_W = LANE_W * LANES;
    localparam int SH_W   = $clog2(DATA_W + 1);
    localparam int CNT_W  = $clog2(LANES);

    width_e           cfg_mode;
    logic             cfg_big;
    logic [SH_W-1:0]  cfg_part_w;
    logic [CNT_W-1:0] cfg_last;
    logic             any_rst;

    assign any_rst = !mrst_n || !prst_n;

    bwm_cfg #(.LANE_W(LANE_W), .LANES(LANES)) cfg_i (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .narrow_en  (narrow_en),
        .lane_sel   (lane_sel),
        .big_sel    (big_sel),
        .mode_q     (cfg_mode),
        .big_q      (cfg_big),
        .part_w_q   (cfg_part_w),
        .last_idx_q (cfg_last)
    );

    bwm_unpack #(.DATA_W(DATA_W), .SH_W(SH_W), .CNT_W(CNT_W)) unpack_i (
        .clk           (clk),
        .clr           (any_rst),
        .big           (cfg_big),
        .part_w        (cfg_part_w),
        .last_idx      (cfg_last),
        .port_rd_req   (port_rd_req),
        .port_rd_rdy   (port_rd_rdy),
        .port_rd_vld   (port_rd_vld),
        .port_rd_data  (port_rd_data),
        .rd_fifo_valid (rd_fifo_valid),
        .rd_fifo_data  (rd_fifo_data),
        .rd_fifo_pop   (rd_fifo_pop)
    );

    bwm_pack #(.DATA_W(DATA_W), .SH_W(SH_W), .CNT_W(CNT_W)) pack_i (
        .clk           (clk),
        .clr           (any_rst),
        .big           (cfg_big),
        .part_w        (cfg_part_w),
        .last_idx      (cfg_last),
        .port_wr_req   (port_wr_req),
        .port_wr_data  (port_wr_data),
        .port_wr_rdy   (port_wr_rdy),
        .wr_fifo_ready (wr_fifo_ready),
        .wr_fifo_push  (wr_fifo_push),
        .wr_fifo_data  (wr_fifo_data)
    );

endmodule

// File: rtl/bwm_chk.sv
module bwm_chk
    import bwm_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int LANE_W = 9
) (
    input logic              clk,
    input logic              mrst_n,
    input logic              prst_n,
    input logic              port_rd_req,
    input logic              port_rd_rdy,
    input logic              port_rd_vld,
    input logic [DATA_W-1:0] port_rd_data,
    input logic              rd_fifo_valid,
    input logic              rd_fifo_pop,
    input logic              port_wr_req,
    input logic              port_wr_rdy,
    input logic              wr_fifo_ready,
    input logic              wr_fifo_push,
    input width_e            cfg_mode
);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        (!mrst_n || !prst_n) |-> (!rd_fifo_pop && !wr_fifo_push && !port_rd_rdy && !port_wr_rdy));

    // R7
    pop_on_demand_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        rd_fifo_pop |-> (port_rd_req && rd_fifo_valid));

    // R8
    push_gated_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        wr_fifo_push |-> (port_wr_req && wr_fifo_ready));

    // R10
    rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (port_rd_req && port_rd_rdy) |=> port_rd_vld);

    // R10
    rd_idle_quiet_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        !(port_rd_req && port_rd_rdy) |=> !port_rd_vld);

    // R1
    lane_zero_ext_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (port_rd_vld && cfg_mode == WIDTH_LANE) |-> (port_rd_data[DATA_W-1:LANE_W] == '0));

endmodule

bind bus_width_matcher bwm_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (
    .clk           (clk),
    .mrst_n        (mrst_n),
    .prst_n        (prst_n),
    .port_rd_req   (port_rd_req),
    .port_rd_rdy   (port_rd_rdy),
    .port_rd_vld   (port_rd_vld),
    .port_rd_data  (port_rd_data),
    .rd_fifo_valid (rd_fifo_valid),
    .rd_fifo_pop   (rd_fifo_pop),
    .port_wr_req   (port_wr_req),
    .port_wr_rdy   (port_wr_rdy),
    .wr_fifo_ready (wr_fifo_ready),
    .wr_fifo_push  (wr_fifo_push),
    .cfg_mode      (cfg_mode)
);

// File: tb/bus_width_matcher_tb.sv
module bus_width_matcher_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        mrst_n = 1'b0, prst_n = 1'b1;
    logic        narrow_en = 1'b1, lane_sel = 1'b1, big_sel = 1'b1;
    logic        port_rd_req = 1'b0, rd_fifo_valid = 1'b0;
    logic [35:0] rd_fifo_data = '0;
    logic        port_wr_req = 1'b0, wr_fifo_ready = 1'b1;
    logic [35:0] port_wr_data = '0;
    logic        port_rd_rdy, port_rd_vld, rd_fifo_pop;
    logic        port_wr_rdy, wr_fifo_push;
    logic [35:0] port_rd_data, wr_fifo_data;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_width_matcher dut_i (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .narrow_en(narrow_en), .lane_sel(lane_sel), .big_sel(big_sel),
        .port_rd_req(port_rd_req), .port_rd_rdy(port_rd_rdy),
        .port_rd_vld(port_rd_vld), .port_rd_data(port_rd_data),
        .rd_fifo_valid(rd_fifo_valid), .rd_fifo_data(rd_fifo_data),
        .rd_fifo_pop(rd_fifo_pop),
        .port_wr_req(port_wr_req), .port_wr_data(port_wr_data),
        .port_wr_rdy(port_wr_rdy), .wr_fifo_ready(wr_fifo_ready),
        .wr_fifo_push(wr_fifo_push), .wr_fifo_data(wr_fifo_data)
    );

    task automatic chk(input bit ok, input string rq, input logic [35:0] act,
                       input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Master reset with a configuration; checks quiet outputs during and after (R11)
    task automatic do_mrst(input logic bm, input logic sz, input logic be);
        @(negedge clk);
        mrst_n = 1'b0; narrow_en = bm; lane_sel = sz; big_sel = be;
        port_rd_req = 1'b1; port_wr_req = 1'b1;
        rd_fifo_valid = 1'b1; wr_fifo_ready = 1'b1;
        @(negedge clk);
        #1;
        chk(!rd_fifo_pop && !wr_fifo_push && !port_rd_rdy && !port_wr_rdy,
            "R11 quiet in master reset",
            {32'd0, rd_fifo_pop, wr_fifo_push, port_rd_rdy, port_wr_rdy}, 36'd0);
        port_rd_req = 1'b0; port_wr_req = 1'b0;
        @(negedge clk);
        mrst_n = 1'b1;
        @(negedge clk);
        chk(!port_rd_vld && port_rd_data == '0, "R11 read outputs after reset",
            port_rd_data | {35'd0, port_rd_vld}, 36'd0);
    endtask

    task automatic rd_sub(input logic exp_pop, input logic [35:0] exp, input string rq);
        @(negedge clk);
        port_rd_req = 1'b1;
        #1;
        chk(rd_fifo_pop == exp_pop, {rq, " pop"}, {35'd0, rd_fifo_pop}, {35'd0, exp_pop});
        @(negedge clk);
        port_rd_req = 1'b0;
        chk(port_rd_vld && port_rd_data == exp, {rq, " data"}, port_rd_data, exp);
    endtask

    task automatic wr_sub(input logic [35:0] d, input logic exp_push,
                          input logic [35:0] exp_word, input string rq);
        @(negedge clk);
        port_wr_req = 1'b1; port_wr_data = d;
        #1;
        chk(wr_fifo_push == exp_push, {rq, " push"}, {35'd0, wr_fifo_push}, {35'd0, exp_push});
        if (exp_push)
            chk(wr_fifo_data == exp_word, {rq, " word"}, wr_fifo_data, exp_word);
        @(negedge clk);
        port_wr_req = 1'b0;
    endtask

    function automatic logic [35:0] z9(input logic [8:0] v);
        return {27'd0, v};
    endfunction

    function automatic logic [35:0] z18(input logic [17:0] v);
        return {18'd0, v};
    endfunction

    task automatic t_read_byte_big;
        do_mrst(1'b1, 1'b1, 1'b1);
        rd_fifo_data = {9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4};
        rd_sub(1'b1, z9(9'h1A1), "R3 byte big p0");
        rd_sub(1'b0, z9(9'h0B2), "R3 byte big p1");
        rd_sub(1'b0, z9(9'h1C3), "R3 byte big p2");
        rd_sub(1'b0, z9(9'h0D4), "R7 byte big p3");
        rd_fifo_data = {9'h011, 9'h022, 9'h033, 9'h044};
        rd_sub(1'b1, z9(9'h011), "R7 next group pops");
    endtask

    task automatic t_read_byte_little;
        do_mrst(1'b1, 1'b1, 1'b0);
        rd_fifo_data = {9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4};
        rd_sub(1'b1, z9(9'h0D4), "R4 byte little p0");
        rd_sub(1'b0, z9(9'h1C3), "R4 byte little p1");
        rd_sub(1'b0, z9(9'h0B2), "R4 byte little p2");
        rd_sub(1'b0, z9(9'h1A1), "R4 byte little p3");
    endtask

    task automatic t_read_half;
        do_mrst(1'b1, 1'b0, 1'b1);
        rd_fifo_data = {18'h2ABCD, 18'h01234};
        rd_sub(1'b1, z18(18'h2ABCD), "R1 R3 word big p0");
        rd_sub(1'b0, z18(18'h01234), "R3 word big p1");
        do_mrst(1'b1, 1'b0, 1'b0);
        rd_sub(1'b1, z18(18'h01234), "R1 R4 word little p0");
        rd_sub(1'b0, z18(18'h2ABCD), "R4 word little p1");
    endtask

    task automatic t_read_long;
        do_mrst(1'b0, 1'b1, 1'b0);
        rd_fifo_data = 36'h9_8765_4321;
        rd_sub(1'b1, 36'h9_8765_4321, "R1 long read 0");
        rd_fifo_data = 36'h1_2345_6789;
        rd_sub(1'b1, 36'h1_2345_6789, "R1 R7 long read 1");
    endtask

    task automatic t_write;
        do_mrst(1'b1, 1'b1, 1'b1);
        wr_sub({27'h7FFFFFF, 9'h1A1}, 1'b0, '0, "R8 byte big w0");
        wr_sub({27'h5555555, 9'h0B2}, 1'b0, '0, "R8 byte big w1");
        wr_sub({27'h2AAAAAA, 9'h1C3}, 1'b0, '0, "R8 byte big w2");
        wr_sub({27'h7FFFFFF, 9'h0D4}, 1'b1, {9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4}, "R5 byte big w3");
        do_mrst(1'b1, 1'b1, 1'b0);
        wr_sub(z9(9'h1A1), 1'b0, '0, "R6 byte little w0");
        wr_sub(z9(9'h0B2), 1'b0, '0, "R6 byte little w1");
        wr_sub(z9(9'h1C3), 1'b0, '0, "R6 byte little w2");
        wr_sub(z9(9'h0D4), 1'b1, {9'h0D4, 9'h1C3, 9'h0B2, 9'h1A1}, "R6 byte little w3");
        do_mrst(1'b1, 1'b0, 1'b0);
        wr_sub({18'h3FFFF, 18'h3C0F1}, 1'b0, '0, "R6 word little w0");
        wr_sub(z18(18'h00A5A), 1'b1, {18'h00A5A, 18'h3C0F1}, "R1 R6 word little w1");
        do_mrst(1'b0, 1'b0, 1'b1);
        wr_sub(36'hF_0F0F_0F0F, 1'b1, 36'hF_0F0F_0F0F, "R1 long write");
    endtask

    task automatic t_write_stall;
        do_mrst(1'b1, 1'b0, 1'b1);
        wr_fifo_ready = 1'b0;
        @(negedge clk);
        port_wr_req = 1'b1; port_wr_data = z18(18'h12345);
        #1;
        chk(port_wr_rdy && !wr_fifo_push, "R8 first part accepted while full",
            {34'd0, port_wr_rdy, wr_fifo_push}, 36'd2);
        @(negedge clk);
        port_wr_data = z18(18'h06789);
        #1;
        chk(!port_wr_rdy && !wr_fifo_push, "R8 last part held while full",
            {34'd0, port_wr_rdy, wr_fifo_push}, 36'd0);
        @(negedge clk);
        wr_fifo_ready = 1'b1;
        #1;
        chk(port_wr_rdy && wr_fifo_push, "R8 push once ready",
            {34'd0, port_wr_rdy, wr_fifo_push}, 36'd3);
        chk(wr_fifo_data == {18'h12345, 18'h06789}, "R5 stalled word",
            wr_fifo_data, {18'h12345, 18'h06789});
        @(negedge clk);
        port_wr_req = 1'b0;
    endtask

    task automatic t_partial_reset;
        do_mrst(1'b1, 1'b1, 1'b1);
        rd_fifo_data = {9'h101, 9'h102, 9'h103, 9'h104};
        rd_sub(1'b1, z9(9'h101), "R9 pre part read");
        wr_sub(z9(9'h0EE), 1'b0, '0, "R9 pre part write");
        // R2: pins move after master reset; must be ignored
        narrow_en = 1'b0; lane_sel = 1'b0; big_sel = 1'b0;
        @(negedge clk);
        prst_n = 1'b0;
        port_rd_req = 1'b1;
        #1;
        chk(!port_rd_rdy && !rd_fifo_pop, "R11 quiet in partial reset",
            {34'd0, port_rd_rdy, rd_fifo_pop}, 36'd0);
        @(negedge clk);
        port_rd_req = 1'b0;
        prst_n = 1'b1;
        rd_fifo_data = {9'h111, 9'h122, 9'h133, 9'h144};
        rd_sub(1'b1, z9(9'h111), "R9 R2 fresh pop after partial reset");
        rd_sub(1'b0, z9(9'h122), "R2 byte big kept");
        wr_sub(z9(9'h001), 1'b0, '0, "R9 new group w0");
        wr_sub(z9(9'h002), 1'b0, '0, "R9 new group w1");
        wr_sub(z9(9'h003), 1'b0, '0, "R9 new group w2");
        wr_sub(z9(9'h004), 1'b1, {9'h001, 9'h002, 9'h003, 9'h004}, "R9 R2 new group w3");
    endtask

    task automatic t_read_empty;
        do_mrst(1'b0, 1'b0, 1'b1);
        rd_fifo_valid = 1'b0;
        @(negedge clk);
        port_rd_req = 1'b1;
        #1;
        chk(!port_rd_rdy && !rd_fifo_pop, "R10 not ready when empty",
            {34'd0, port_rd_rdy, rd_fifo_pop}, 36'd0);
        @(negedge clk);
        port_rd_req = 1'b0;
        chk(!port_rd_vld, "R10 no valid after refused read", {35'd0, port_rd_vld}, 36'd0);
        rd_fifo_valid = 1'b1;
        rd_fifo_data = 36'hA_BCDE_F012;
        rd_sub(1'b1, 36'hA_BCDE_F012, "R10 read once data arrives");
    endtask

    initial begin
        t_read_byte_big();
        t_read_byte_little();
        t_read_half();
        t_read_long();
        t_write();
        t_write_stall();
        t_partial_reset();
        t_read_empty();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule